// File: doc/BRIEF.md
# Departure-Aware Parallel Buffer Allocator

This block sits between the inputs of a switch and a bank of parallel buffers that feed one output. In every slot up to N packets can arrive for that output at once, each carrying the slot in which it is scheduled to leave. The block gives each packet a buffer index. It obeys two rules. First, no buffer takes more than one write in a slot. Second, no buffer ever holds two packets that are due to leave in the same slot.

A bitmap per buffer tracks the departure slots that buffer already holds, over a circular window of W slots. A bit is set when a packet is granted. It is cleared on the clock edge that ends its slot. The lanes are served in ascending index order, and each lane takes the lowest legal buffer. The bank size follows the pigeonhole bound. In FIFO mode it is 2N-1 buffers, and in push-in-first-out mode it is 4N-2 buffers. Under those sizes and their traffic assumptions, the allocation always succeeds.

Top module: `balloc_top`

## Requirements
- R1: A grant appears on the lane's outputs on the clock edge after the request is sampled. `gnt_valid[i]` is high only if `req_valid[i]` was high at that earlier edge.
- R2: Two lanes granted in the same cycle never receive the same buffer index.
- R3: A buffer that holds a packet due in slot t is not granted to another packet due in slot t until the edge at which the internal slot counter equals t. From that edge on, it is free again for t.
- R4: Lanes are served in ascending index order. Each valid lane receives the lowest-numbered buffer that is neither taken by a lower lane in the same cycle nor barred by R3.
- R5: Departure times are compared on their low log2(W) bits. The slot counter is 0 at the first edge after reset, rises by one per edge and wraps modulo W.
- R6: The bank holds M = 2N-1 buffers when PRIO=0 and M = 4N-2 when PRIO=1. Every granted index is below M.
- R7: When a valid lane finds no legal buffer, `alloc_err` is high in the same cycle as the grants, and that lane's `gnt_valid` is low. The other lanes are still granted under R4.
- R8: While `rst_n` is low, all grants and `alloc_err` are low. Reset also clears every departure bitmap.
- R9: Traffic within the sizing (at most N packets per slot, departures inside the window) produces no `alloc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N | Packet present on each lane |
| req_time | input | N x log2(W) | Departure slot of each lane's packet, modulo W |
| gnt_valid | output | N | Lane was given a buffer |
| gnt_buf | output | N x log2(M) | Buffer index given to each lane |
| alloc_err | output | 1 | Some valid lane found no legal buffer |

## Verification
The hard cycles are those where the per-slot write exclusion and the departure-slot exclusion act on the same lane together. The bench builds them by sending several packets with a shared departure slot across consecutive cycles. Each later lane then has to skip both the buffers taken by lower lanes in that cycle and the buffers already holding that departure. The expected index is the first buffer that survives both filters. A final cycle exhausts all seven buffers of the FIFO-sized bank for one departure slot, while a parallel PRIO-sized instance still finds buffers 7 and 8.

// File: rtl/balloc_pkg.sv
// Package: shared sizing helpers for the parallel buffer allocator.
// Assumes: n >= 1.
package balloc_pkg;

    // Number of parallel buffers required by the pigeonhole bound for the mode.
    function automatic int unsigned nbuf(input int unsigned n, input bit prio);
        return prio ? (4 * n - 2) : (2 * n - 1);
    endfunction

endpackage

// File: rtl/balloc_pick.sv
// Module: lowest-set-bit finder over an availability vector.
// Assumes: M >= 1, BW wide enough to hold M-1.
module balloc_pick #(
    parameter int M  = 7,
    parameter int BW = 3
) (
    input  logic [M-1:0]  avail,
    output logic          found,
    output logic [BW-1:0] idx
);

    // Scan downward so the last hit kept is the lowest index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int b = M - 1; b >= 0; b--) begin
            if (avail[b]) begin
                found = 1'b1;
                idx   = BW'(b);
            end
        end
    end

endmodule

// File: rtl/balloc_chain.sv
// Module: lane-ordered allocation chain. Lane i picks among buffers that
// are free of its departure slot and not already taken by lanes 0..i-1.
// Assumes: conflict[i] already reflects lane i's departure slot.
module balloc_chain #(
    parameter int N  = 4,
    parameter int M  = 7,
    parameter int BW = 3
) (
    input  logic [N-1:0]         req_valid,
    input  logic [N-1:0][M-1:0]  conflict,
    output logic [N-1:0]         g_ok,
    output logic [N-1:0][BW-1:0] g_idx,
    output logic [N-1:0]         miss
);

    logic [N:0][M-1:0] used;

    assign used[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [M-1:0]  avail;
        logic          found;
        logic [BW-1:0] idx;

        // Candidate buffers for this lane.
        assign avail = ~conflict[i] & ~used[i] & {M{req_valid[i]}};

        balloc_pick #(.M(M), .BW(BW)) u_pick (
            .avail (avail),
            .found (found),
            .idx   (idx)
        );

        assign g_ok[i]   = found;
        assign g_idx[i]  = idx;
        assign miss[i]   = req_valid[i] & ~found;
        // Mark the chosen buffer as written in this slot for later lanes.
        assign used[i+1] = used[i] | (found ? (M'(1) << idx) : M'(0));
    end

endmodule

// File: rtl/balloc_occ.sv
// Module: per-buffer departure bitmaps over a circular window of W slots.
// A bit is cleared on the edge whose slot equals its position; new grants
// set bits on the same edge (set wins).
// Assumes: W is a power of two; grants never target the current slot.
module balloc_occ #(
    parameter int M  = 7,
    parameter int W  = 16,
    parameter int TW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TW-1:0]       now,
    input  logic [M-1:0][W-1:0] set_map,
    output logic [M-1:0][W-1:0] busy
);

    logic [W-1:0] clr;

    // One-hot of the slot that passes at this edge.
    assign clr = W'(1) << now;

    for (genvar b = 0; b < M; b++) begin : g_buf
        // Retire the passing slot, record new departures.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[b] <= '0;
            end else begin
                busy[b] <= (busy[b] & ~clr) | set_map[b];
            end
        end
    end

endmodule

// File: rtl/balloc_top.sv
// Module: conflict-free parallel buffer allocator for one output.
// Each slot, valid lanes are given distinct buffers that hold no packet
// due in the same departure slot. Grants are registered.
// Assumes: departure times lie 1..W-1 slots ahead of the slot counter.
module balloc_top
    import balloc_pkg::*;
#(
    parameter int  N    = 4,
    parameter int  W    = 16,
    parameter bit  PRIO = 1'b0,
    localparam int M    = int'(nbuf(N, PRIO)),
    localparam int TW   = $clog2(W),
    localparam int BW   = $clog2(M)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req_valid,
    input  logic [N-1:0][TW-1:0] req_time,
    output logic [N-1:0]         gnt_valid,
    output logic [N-1:0][BW-1:0] gnt_buf,
    output logic                 alloc_err
);

    logic [TW-1:0]         now;
    logic [M-1:0][W-1:0]   busy;
    logic [M-1:0][W-1:0]   set_map;
    logic [N-1:0][M-1:0]   conflict;
    logic [N-1:0]          g_ok;
    logic [N-1:0][BW-1:0]  g_idx;
    logic [N-1:0]          miss;

    // Slot counter, modulo W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '0;
        end else begin
            now <= now + 1'b1;
        end
    end

    // Per-lane view of which buffers already hold that lane's departure slot.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int b = 0; b < M; b++) begin
                conflict[i][b] = busy[b][req_time[i]];
            end
        end
    end

    balloc_chain #(.N(N), .M(M), .BW(BW)) u_chain (
        .req_valid (req_valid),
        .conflict  (conflict),
        .g_ok      (g_ok),
        .g_idx     (g_idx),
        .miss      (miss)
    );

    // Translate this slot's grants into bitmap set requests.
    always_comb begin
        set_map = '0;
        for (int i = 0; i < N; i++) begin
            if (g_ok[i]) begin
                set_map[g_idx[i]][req_time[i]] = 1'b1;
            end
        end
    end

    balloc_occ #(.M(M), .W(W), .TW(TW)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .now     (now),
        .set_map (set_map),
        .busy    (busy)
    );

    // Register grants and the allocation error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= '0;
            gnt_buf   <= '0;
            alloc_err <= 1'b0;
        end else begin
            gnt_valid <= g_ok;
            gnt_buf   <= g_idx;
            alloc_err <= |miss;
        end
    end

endmodule

// File: rtl/balloc_chk.sv
// Module: assertion checker for balloc_top, attached by bind.
// Assumes: same parameters as the bound instance.
module balloc_chk #(
    parameter int N  = 4,
    parameter int M  = 7,
    parameter int TW = 4,
    parameter int BW = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N-1:0]         req_valid,
    input logic [N-1:0][TW-1:0] req_time,
    input logic [N-1:0]         gnt_valid,
    input logic [N-1:0][BW-1:0] gnt_buf,
    input logic                 alloc_err
);

    logic live;

    // Goes high one edge after reset so $past never reaches into reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R7: the error flag matches exactly the cycles where a request was dropped.
    p_err_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (alloc_err == (gnt_valid != $past(req_valid))));

    for (genvar i = 0; i < N; i++) begin : g_i
        // R1: a grant needs a request one edge earlier.
        p_grant_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (live && gnt_valid[i]) |-> $past(req_valid[i]));
        // R6: indices stay inside the bank.
        p_index_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[i] |-> (int'(gnt_buf[i]) < M));
        for (genvar j = i + 1; j < N; j++) begin : g_j
            // R2: one write per buffer per slot.
            p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_valid[i] && gnt_valid[j]) |-> (gnt_buf[i] != gnt_buf[j]));
        end
    end

endmodule

bind balloc_top balloc_chk #(.N(N), .M(M), .TW(TW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_time  (req_time),
    .gnt_valid (gnt_valid),
    .gnt_buf   (gnt_buf),
    .alloc_err (alloc_err)
);

// File: tb/sim_balloc_top.sv
// Bench: vector table walk, then directed reset and bank-exhaustion tests.
module sim_balloc_top;

    localparam int N   = 4;
    localparam int W   = 16;
    localparam int NV  = 9;
    localparam int VWD = 36;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [N-1:0]        req_valid;
    logic [N-1:0][3:0]   req_time;
    logic [N-1:0]        gv0, gv1;
    logic [N-1:0][2:0]   gb0;
    logic [N-1:0][3:0]   gb1;
    logic                err0, err1;
    int                  n_vec = 0;
    int                  n_bad = 0;

    always #10 clk = ~clk;

    balloc_top #(.N(N), .W(W), .PRIO(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_time(req_time),
        .gnt_valid(gv0), .gnt_buf(gb0), .alloc_err(err0));

    balloc_top #(.N(N), .W(W), .PRIO(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_time(req_time),
        .gnt_valid(gv1), .gnt_buf(gb1), .alloc_err(err1));

    // Pack one vector: request valids, times lane3..0, expected valids, buffers lane3..0.
    function automatic logic [VWD-1:0] vec(input logic [3:0] v,
        input logic [3:0] t3, input logic [3:0] t2, input logic [3:0] t1, input logic [3:0] t0,
        input logic [3:0] ev,
        input logic [2:0] b3, input logic [2:0] b2, input logic [2:0] b1, input logic [2:0] b0);
        return {v, t3, t2, t1, t0, ev, b3, b2, b1, b0};
    endfunction

    // Vector j is sampled when the slot counter equals j (FIFO bank of 7).
    localparam logic [VWD-1:0] TBL [NV] = '{
        vec(4'b1111, 4'd5, 4'd5, 4'd5, 4'd5, 4'b1111, 3'd3, 3'd2, 3'd1, 3'd0), // R2 same slot, same time
        vec(4'b0011, 4'd0, 4'd0, 4'd6, 4'd5, 4'b0011, 3'd0, 3'd0, 3'd0, 3'd4), // R3 skip holders of t5
        vec(4'b1111, 4'd6, 4'd5, 4'd7, 4'd6, 4'b1111, 3'd2, 3'd5, 3'd0, 3'd1), // R4 both filters at once
        vec(4'b0000, 4'd0, 4'd0, 4'd0, 4'd0, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0), // R1 idle
        vec(4'b1000, 4'd5, 4'd0, 4'd0, 4'd0, 4'b1000, 3'd6, 3'd0, 3'd0, 3'd0), // R3 last buffer for t5
        vec(4'b0001, 4'd0, 4'd0, 4'd0, 4'd9, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd0), // R4 fresh slot
        vec(4'b0001, 4'd0, 4'd0, 4'd0, 4'd5, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd0), // R5 t21 wraps to 5
        vec(4'b0010, 4'd0, 4'd0, 4'd6, 4'd0, 4'b0010, 3'd0, 3'd0, 3'd0, 3'd0), // R5 t22 wraps to 6
        vec(4'b0001, 4'd0, 4'd0, 4'd0, 4'd12, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd0) // R3 seed t12 in buffer 0
    };

    string tags [NV] = '{"R2", "R3", "R4", "R1", "R3", "R4", "R5", "R5", "R3"};

    // Count one comparison and report a mismatch.
    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = '0;
        req_time  = '0;
        repeat (3) @(negedge clk);
        // R8: reset state.
        chk("R8", "gnt_valid in reset", int'(gv0), 0);
        chk("R8", "alloc_err in reset", int'(err0), 0);

        rst_n = 1'b1;
        for (int j = 0; j < NV; j++) begin
            logic [VWD-1:0] e;
            e = TBL[j];
            req_valid = e[35:32];
            req_time  = e[31:16];
            @(negedge clk);
            chk(tags[j], $sformatf("vec%0d gnt_valid", j), int'(gv0), int'(e[15:12]));
            chk("R9", $sformatf("vec%0d alloc_err", j), int'(err0), 0);
            for (int i = 0; i < N; i++) begin
                if (e[12+i]) begin
                    chk(tags[j], $sformatf("vec%0d lane%0d buf", j, i),
                        int'(gb0[i]), int'(e[3*i +: 3]));
                end
            end
        end

        // R8: reset mid-run, outputs drop and bitmaps clear.
        req_valid = '0;
        rst_n     = 1'b0;
        @(negedge clk);
        chk("R8", "gnt_valid after reset", int'(gv0), 0);
        rst_n = 1'b1;

        // Slot 0: four t12 packets; buffer 0 is free again only if reset cleared it.
        req_valid = 4'b1111;
        req_time  = {4'd12, 4'd12, 4'd12, 4'd12};
        @(negedge clk);
        chk("R8", "lane0 buf after reset", int'(gb0[0]), 0);
        chk("R2", "lane3 buf", int'(gb0[3]), 3);

        // Slot 1: three more t12 packets fill the FIFO-sized bank.
        req_valid = 4'b0111;
        @(negedge clk);
        chk("R3", "lane0 buf", int'(gb0[0]), 4);
        chk("R3", "lane2 buf", int'(gb0[2]), 6);
        chk("R9", "alloc_err at full", int'(err0), 0);

        // Slot 2: two t12 packets cannot fit in 7 buffers; lane2 t13 still fits.
        req_time = {4'd0, 4'd13, 4'd12, 4'd12};
        @(negedge clk);
        chk("R7", "gnt_valid on overflow", int'(gv0), 4'b0100);
        chk("R7", "alloc_err on overflow", int'(err0), 1);
        chk("R7", "lane2 buf beside overflow", int'(gb0[2]), 0);
        chk("R6", "prio bank gnt_valid", int'(gv1), 4'b0111);
        chk("R6", "prio bank lane0 buf", int'(gb1[0]), 7);
        chk("R6", "prio bank lane1 buf", int'(gb1[1]), 8);
        chk("R6", "prio bank alloc_err", int'(err1), 0);

        // R1: request removed, grants drop on the next edge.
        req_valid = '0;
        @(negedge clk);
        chk("R1", "gnt_valid idle", int'(gv0), 0);
        chk("R7", "alloc_err clears", int'(err0), 0);

        summary();
        $finish;
    end

endmodule